// File: doc/BRIEF.md
# Tracking Converter Angle Output Stage

This block connects the up/down angle counter of a tracking angle converter to a host bus that is shared and byte-wide. Each time the counter takes a one-LSB step, the block raises a busy pulse of fixed length. The pulse tells the host that the angle is in motion. A minimum idle gap always separates two pulses. A step that arrives too early is held back and is not lost.

A hold register normally follows the counter on every clock. An active-low freeze input stops it, and the counter keeps moving underneath. If the freeze arrives while busy is high, the register keeps following until the busy pulse has ended. It then freezes on a settled value, so the host never reads a word that is halfway through an update.

The 14-bit angle goes out on two byte lanes. Each lane has its own active-low enable and its own output-enable for an external tri-state driver. The upper lane carries the eight most significant bits. The lower lane carries the six least significant bits, left-justified, with zeros below them. With both enables held low, the full word is presented at once for a 16-bit bus.

Top module: `rdl_out_latch`

## Requirements
- R1: Each step strobe that is accepted gives exactly one busy pulse. A step that arrives during a pulse or its gap is deferred, and any number of such steps merge into one held request.
- R2: `busy_o` rises in the cycle after the clock edge that samples `step_i` in idle, and stays high for exactly `BUSY_CYC` cycles.
- R3: Between two busy pulses `busy_o` is low for at least `GAP_CYC` cycles. A held request starts its pulse as soon as the gap has run out.
- R4: While `inh_n` is 1 and no freeze is in force, the hold register loads `cnt_val` on every clock edge, including while busy is high.
- R5: While frozen, the hold register keeps its value whatever `cnt_val` does. After `inh_n` returns to 1, it shows the live counter value again within two clocks.
- R6: If `inh_n` falls while `busy_o` is high, the register keeps tracking until the first clock edge that sees busy low. It freezes there.
- R7: With `en_hi_n` = 0, `bus_oe[1]` = 1 and `bus_d[15:8]` = angle bits 13..6.
- R8: With `en_lo_n` = 0, `bus_oe[0]` = 1 and `bus_d[7:0]` = {angle bits 5..0, 2'b00}.
- R9: A lane whose enable is 1 has its `bus_oe` bit at 0 and its `bus_d` byte at zero.
- R10: With both enables at 0, the full 16-bit word appears on `bus_d` and both `bus_oe` bits are 1.
- R11: While `rst` is high, the hold register is cleared, `busy_o` is 0 and `bus_oe` is 2'b00 whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 14 | Live angle from the tracking counter |
| step_i | input | 1 | One-cycle strobe: the counter moved by one LSB |
| inh_n | input | 1 | Active-low freeze request for the hold register |
| en_hi_n | input | 1 | Active-low enable for the upper byte lane |
| en_lo_n | input | 1 | Active-low enable for the lower byte lane |
| busy_o | output | 1 | Converter-busy pulse |
| bus_d | output | 16 | Lane data: [15:8] upper byte, [7:0] lower byte |
| bus_oe | output | 2 | Per-lane tri-state driver enable: [1] upper, [0] lower |

## Verification
The bench builds the block with `BUSY_CYC` = 3 and `GAP_CYC` = 2. With these values one step history of twenty clocks holds a full pulse, its gap, a deferred pulse and the merging of back-to-back early steps. A three-cycle pulse also leaves room to move the counter twice while busy is high and the freeze is pending. This shows that the register tracks up to the edge where busy ends and freezes only there. The default values, 47 and 19 cycles, make the same checks run longer but test nothing new.

// File: rtl/rdl_out_pkg.sv
package rdl_out_pkg;

    localparam int ANG_W  = 14;
    localparam int BYTE_W = 8;
    localparam int LANES  = 2;
    localparam int LO_W   = ANG_W - BYTE_W;
    localparam int PAD_W  = BYTE_W - LO_W;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_BUSY = 2'd1,
        PH_GAP  = 2'd2
    } pulse_ph_t;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } lane_pair_t;

    function automatic lane_pair_t split_angle(input logic [ANG_W-1:0] ang);
        lane_pair_t r;
        r.hi = ang[ANG_W-1:LO_W];
        r.lo = {ang[LO_W-1:0], {PAD_W{1'b0}}};
        return r;
    endfunction

endpackage

// File: rtl/rdl_pulse_gen.sv
module rdl_pulse_gen
    import rdl_out_pkg::*;
#(
    parameter int BUSY_CYC = 47,
    parameter int GAP_CYC  = 19
) (
    input  logic clk,
    input  logic rst,
    input  logic step_i,
    output logic busy_o
);
    localparam int MAXC = (BUSY_CYC > GAP_CYC) ? BUSY_CYC : GAP_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] BUSY_LD = CW'(BUSY_CYC - 1);
    localparam logic [CW-1:0] GAP_LD  = CW'(GAP_CYC - 1);

    pulse_ph_t      ph_q;
    logic [CW-1:0]  cnt_q;
    logic           pend_q;
    logic           take;

    assign take = pend_q | step_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (take) begin
                        ph_q   <= PH_BUSY;
                        cnt_q  <= BUSY_LD;
                        pend_q <= 1'b0;
                    end
                end
                PH_BUSY: begin
                    if (step_i) pend_q <= 1'b1;
                    if (cnt_q == '0) begin
                        ph_q  <= PH_GAP;
                        cnt_q <= GAP_LD;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_GAP: begin
                    if (cnt_q == '0) begin
                        if (take) begin
                            ph_q   <= PH_BUSY;
                            cnt_q  <= BUSY_LD;
                            pend_q <= 1'b0;
                        end else begin
                            ph_q <= PH_IDLE;
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                        if (step_i) pend_q <= 1'b1;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign busy_o = (ph_q == PH_BUSY);

endmodule

// File: rtl/rdl_hold_latch.sv
module rdl_hold_latch
    import rdl_out_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             inh_n,
    input  logic             busy,
    input  logic [ANG_W-1:0] cnt_val,
    output logic [ANG_W-1:0] latch_q,
    output logic             frozen_q
);
    // Freeze takes hold only on an edge that sees busy low; once frozen it
    // stays frozen until the request is withdrawn.
    logic frz_d;
    assign frz_d = ~inh_n & (frozen_q | ~busy);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q  <= '0;
            frozen_q <= 1'b0;
        end else begin
            if (!frozen_q) latch_q <= cnt_val;
            frozen_q <= frz_d;
        end
    end

endmodule

// File: rtl/rdl_lane_drv.sv
module rdl_lane_drv
    import rdl_out_pkg::*;
(
    input  logic                    rst,
    input  logic [ANG_W-1:0]        angle,
    input  logic [LANES-1:0]        en_n,
    output logic [LANES*BYTE_W-1:0] bus_d,
    output logic [LANES-1:0]        bus_oe
);
    lane_pair_t             pair;
    logic [BYTE_W-1:0]      lane_src [LANES];

    assign pair        = split_angle(angle);
    assign lane_src[1] = pair.hi;
    assign lane_src[0] = pair.lo;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign bus_oe[g] = ~rst & ~en_n[g];
        assign bus_d[g*BYTE_W +: BYTE_W] = bus_oe[g] ? lane_src[g] : '0;
    end

endmodule

// File: rtl/rdl_out_latch.sv
module rdl_out_latch
    import rdl_out_pkg::*;
#(
    parameter int BUSY_CYC = 47,
    parameter int GAP_CYC  = 19
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ANG_W-1:0]        cnt_val,
    input  logic                    step_i,
    input  logic                    inh_n,
    input  logic                    en_hi_n,
    input  logic                    en_lo_n,
    output logic                    busy_o,
    output logic [LANES*BYTE_W-1:0] bus_d,
    output logic [LANES-1:0]        bus_oe
);
    logic [ANG_W-1:0] latch_q;
    logic             frozen_q;

    rdl_pulse_gen #(
        .BUSY_CYC (BUSY_CYC),
        .GAP_CYC  (GAP_CYC)
    ) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .step_i (step_i),
        .busy_o (busy_o)
    );

    rdl_hold_latch u_hold (
        .clk      (clk),
        .rst      (rst),
        .inh_n    (inh_n),
        .busy     (busy_o),
        .cnt_val  (cnt_val),
        .latch_q  (latch_q),
        .frozen_q (frozen_q)
    );

    rdl_lane_drv u_lane (
        .rst    (rst),
        .angle  (latch_q),
        .en_n   ({en_hi_n, en_lo_n}),
        .bus_d  (bus_d),
        .bus_oe (bus_oe)
    );

endmodule

// File: rtl/rdl_out_latch_chk.sv
module rdl_out_latch_chk
    import rdl_out_pkg::*;
#(
    parameter int BUSY_CYC = 47,
    parameter int GAP_CYC  = 19
) (
    input logic                    clk,
    input logic                    rst,
    input logic [ANG_W-1:0]        cnt_val,
    input logic                    inh_n,
    input logic                    en_hi_n,
    input logic                    en_lo_n,
    input logic                    busy_o,
    input logic [LANES-1:0]        bus_oe,
    input logic [ANG_W-1:0]        latch_q,
    input logic                    frozen_q
);
    localparam int SAT = 1 << 20;

    int run_q;
    int gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 0;
            gap_q <= SAT;
        end else if (busy_o) begin
            run_q <= run_q + 1;
            gap_q <= 0;
        end else begin
            run_q <= 0;
            gap_q <= (gap_q < SAT) ? gap_q + 1 : SAT;
        end
    end

    // R2: every pulse ends after exactly BUSY_CYC high cycles
    a_r2_pulse_width: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (run_q == BUSY_CYC));

    // R3: no pulse starts before the gap has elapsed
    a_r3_min_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (gap_q >= GAP_CYC));

    // R4: unfrozen register follows the counter
    a_r4_track: assert property (@(posedge clk) disable iff (rst)
        !frozen_q |=> (latch_q == $past(cnt_val)));

    // R5: frozen register keeps its value
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        frozen_q |=> $stable(latch_q));

    // R6: the freeze is never taken on an edge that sees busy high
    a_r6_defer: assert property (@(posedge clk) disable iff (rst)
        $rose(frozen_q) |-> (!$past(busy_o) && !$past(inh_n)));

    // R9: a disabled lane never drives
    a_r9_hiz_hi: assert property (@(posedge clk) en_hi_n |-> !bus_oe[1]);
    a_r9_hiz_lo: assert property (@(posedge clk) en_lo_n |-> !bus_oe[0]);

    // R11: reset clears the register and the busy pulse
    a_r11_reset: assert property (@(posedge clk)
        rst |=> (latch_q == '0 && !busy_o && !frozen_q));

    always_comb begin
        a_r11_no_drive: assert (!rst || bus_oe == '0);
    end

endmodule

bind rdl_out_latch rdl_out_latch_chk #(
    .BUSY_CYC (BUSY_CYC),
    .GAP_CYC  (GAP_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt_val  (cnt_val),
    .inh_n    (inh_n),
    .en_hi_n  (en_hi_n),
    .en_lo_n  (en_lo_n),
    .busy_o   (busy_o),
    .bus_oe   (bus_oe),
    .latch_q  (latch_q),
    .frozen_q (frozen_q)
);

// File: tb/rdl_out_latch_test.sv
module rdl_out_latch_test;
    localparam int BCYC = 3;
    localparam int GCYC = 2;
    localparam int NVEC = 8;
    localparam int HLEN = 20;

    // {cnt[13:0], en_hi_n, en_lo_n, oe[1:0], bus_d[15:0]}
    localparam logic [33:0] VEC [NVEC] = '{
        {14'h3FFF, 1'b0, 1'b0, 2'b11, 16'hFFFC},
        {14'h2A55, 1'b1, 1'b0, 2'b01, 16'h0054},
        {14'h2A55, 1'b0, 1'b1, 2'b10, 16'hA900},
        {14'h0001, 1'b1, 1'b1, 2'b00, 16'h0000},
        {14'h0001, 1'b1, 1'b0, 2'b01, 16'h0004},
        {14'h0040, 1'b0, 1'b1, 2'b10, 16'h0100},
        {14'h1234, 1'b0, 1'b0, 2'b11, 16'h48D0},
        {14'h0000, 1'b0, 1'b0, 2'b11, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] cnt_val = '0;
    logic        step_i = 1'b0;
    logic        inh_n = 1'b1;
    logic        en_hi_n = 1'b1;
    logic        en_lo_n = 1'b1;
    logic        busy_o;
    logic [15:0] bus_d;
    logic [1:0]  bus_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rdl_out_latch #(.BUSY_CYC(BCYC), .GAP_CYC(GCYC)) uut (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .step_i(step_i),
        .inh_n(inh_n), .en_hi_n(en_hi_n), .en_lo_n(en_lo_n),
        .busy_o(busy_o), .bus_d(bus_d), .bus_oe(bus_oe)
    );

    function automatic logic [15:0] word_of(input logic [13:0] a);
        return {a[13:6], a[5:0], 2'b00};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic hist [HLEN];
        int rises, run1, low1, run2, idx;

        // R11: reset state with enables low and a busy counter value
        cnt_val = 14'h3FFF; en_hi_n = 1'b0; en_lo_n = 1'b0; step_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 oe", 32'(bus_oe), 32'h0);
        check("R11 data", 32'(bus_d), 32'h0);
        check("R11 busy", 32'(busy_o), 32'h0);
        step_i = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R4, R7..R10: lane table
        for (int i = 0; i < NVEC; i++) begin
            cnt_val = VEC[i][33:20];
            en_hi_n = VEC[i][19];
            en_lo_n = VEC[i][18];
            @(negedge clk);
            check((VEC[i][19] & VEC[i][18]) ? "R9 oe" :
                  (!VEC[i][19] & !VEC[i][18]) ? "R10 oe" :
                  VEC[i][19] ? "R8 oe" : "R7 oe",
                  32'(bus_oe), 32'(VEC[i][17:16]));
            check("R4 R7 R8 data", 32'(bus_d), 32'(VEC[i][15:0]));
        end

        // R1, R2, R3: step history with early steps merged
        en_hi_n = 1'b0; en_lo_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < HLEN; i++) begin
            hist[i] = busy_o;
            step_i = (i == 0 || i == 2 || i == 3);
            @(negedge clk);
        end
        step_i = 1'b0;
        rises = 0;
        for (int i = 1; i < HLEN; i++) if (hist[i] && !hist[i-1]) rises++;
        check("R1 pulse count", 32'(rises), 32'd2);
        check("R2 start", 32'({hist[0], hist[1]}), 32'b01);
        idx = 1; run1 = 0;
        while (idx < HLEN && hist[idx]) begin run1++; idx++; end
        low1 = 0;
        while (idx < HLEN && !hist[idx]) begin low1++; idx++; end
        run2 = 0;
        while (idx < HLEN && hist[idx]) begin run2++; idx++; end
        check("R2 width", 32'(run1), 32'(BCYC));
        check("R3 gap", 32'(low1), 32'(GCYC));
        check("R2 width deferred", 32'(run2), 32'(BCYC));

        // R5: freeze in idle, counter moves underneath
        repeat (4) @(negedge clk);
        cnt_val = 14'h0ABC;
        @(negedge clk);
        inh_n = 1'b0;
        @(negedge clk);
        cnt_val = 14'h1111;
        repeat (3) @(negedge clk);
        check("R5 hold", 32'(bus_d), 32'(word_of(14'h0ABC)));
        inh_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R5 release", 32'(bus_d), 32'(word_of(14'h1111)));

        // R6: freeze requested during busy is deferred
        repeat (4) @(negedge clk);
        step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
        check("R6 busy up", 32'(busy_o), 32'h1);
        inh_n = 1'b0;
        cnt_val = 14'h0155;
        @(negedge clk);
        cnt_val = 14'h2AAA;
        @(negedge clk);
        check("R6 tracks while busy", 32'(bus_d), 32'(word_of(14'h2AAA)));
        while (busy_o) @(negedge clk);
        repeat (2) @(negedge clk);
        cnt_val = 14'h0F0F;
        repeat (2) @(negedge clk);
        check("R6 frozen after busy", 32'(bus_d), 32'(word_of(14'h2AAA)));
        inh_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R5 resume", 32'(bus_d), 32'(word_of(14'h0F0F)));

        // R9: disabled lanes read zero while the register holds data
        en_hi_n = 1'b1; en_lo_n = 1'b1;
        @(negedge clk);
        check("R9 both off", 32'({bus_oe, bus_d}), 32'h0);

        finish_run();
    end

endmodule